// File: doc/BRIEF.md
# GPIO Pad Control Bank

This block keeps two small registers for every pin of a general-purpose pin array: a control word and an I/O word, both reached over a simple word-wide register bus. The control word chooses what drives the pad (the pin's own GPIO output or one of several alternate-function sources), the pull behaviour (none, pull-down, pull-up or keeper) and a drive-strength code. The I/O word holds the value the pin drives in GPIO mode and shows the synchronised level seen on the pad.

The bank turns these settings into resolved per-pin pad signals: output value, output enable, pull-up and pull-down controls, and the drive code. A drive code n stands for a strength of (n+1)*2 mA, so the codes 0..7 cover 2 mA to 16 mA in even steps. Pad inputs pass through a two-stage synchroniser before software or downstream logic sees them. In keeper mode the synchronised level chooses the pull direction, so the pad holds its last level. The pin count is a parameter (up to 300), and so is the number of alternate functions (up to 7).

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset every control word reads 0x008 (GPIO mode, pull-down, drive code 0, output disabled), every I/O output bit is 0, and every pin shows pad_oe=0, pad_pd=1, pad_pu=0 and pad_drv=0.
- R2: The control word of pin p is at byte address p*8 and its I/O word is at p*8+4. A write with bus_we replaces the whole word at the next edge. A read strobe bus_re returns the data on bus_rdata one cycle later. A read in the same cycle as a write to that address returns the previous contents. Addresses past the last pin, or at any other offset, read as 0 and ignore writes.
- R3: Control word fields: bits [2:0] function select, bits [4:3] pull mode, bits [7:5] drive code, bit 8 output enable. Bits 31:9 read as 0.
- R4: I/O word: bit 0 is the GPIO output value (read/write). Bit 1 is the synchronised input (read-only, so writes to it are ignored). All other bits read as 0.
- R5: With function select 0, pad_out[p] equals the I/O output bit and pad_oe[p] equals the control output-enable bit.
- R6: With function select f in 1..7, pad_out[p] = alt_out[(f-1)*NUM_PINS+p] and pad_oe[p] = alt_oe[(f-1)*NUM_PINS+p], whatever the GPIO output and output-enable bits hold.
- R7: Pull mode 0 drives neither pull output, 1 drives pad_pd, 3 drives pad_pu. pad_pu and pad_pd are never both high.
- R8: Pull mode 2 (keeper) drives pad_pu when the synchronised input is 1 and pad_pd when it is 0.
- R9: pad_drv[3p+2:3p] carries pin p's drive code unchanged.
- R10: pad_in passes through two flops. A level change becomes visible in the I/O input bit, on gpio_in and in keeper mode two clock edges after it is sampled. A read strobed in the cycle of the change still returns the old level.
- R11: The I/O input bit follows the pad whatever the direction and function select of the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Full-word write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| pad_in | input | NUM_PINS | Raw pad input levels |
| alt_out | input | NUM_ALT*NUM_PINS | Alternate-function output values, function-major |
| alt_oe | input | NUM_ALT*NUM_PINS | Alternate-function output enables, function-major |
| pad_out | output | NUM_PINS | Resolved pad output value |
| pad_oe | output | NUM_PINS | Resolved pad output enable |
| pad_pu | output | NUM_PINS | Pull-up enable |
| pad_pd | output | NUM_PINS | Pull-down enable |
| pad_drv | output | 3*NUM_PINS | Per-pin drive code |
| gpio_in | output | NUM_PINS | Synchronised pad input |

## Verification
Two functions can land in the same cycle: a bus write and a bus read aimed at the same control word, and a pad level change racing a read of the I/O input bit. The bench raises bus_we and bus_re together on one address and expects the old word back, followed by the new word on the next read. It also changes a pad level in the same cycle as a read strobe and expects the old level from that read and from the one after it. The new level must appear on the third read.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
    localparam int FUNC_W = 3;
    localparam int PULL_W = 2;
    localparam int DRV_W  = 3;
    localparam int CTL_W  = FUNC_W + PULL_W + DRV_W + 1;

    typedef enum logic [PULL_W-1:0] {
        PULL_NONE = 2'd0,
        PULL_DOWN = 2'd1,
        PULL_KEEP = 2'd2,
        PULL_UP   = 2'd3
    } pull_e;

    // bit 8 oe, [7:5] drive, [4:3] pull, [2:0] function
    typedef struct packed {
        logic              oe;
        logic [DRV_W-1:0]  drv;
        pull_e             pull;
        logic [FUNC_W-1:0] func;
    } ctl_t;

    typedef struct packed {
        ctl_t ctl;
        logic out;
    } pin_st_t;

    localparam ctl_t CTL_RST = '{oe: 1'b0, drv: '0, pull: PULL_DOWN, func: '0};
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gpb_pin.sv
module gpb_pin
    import gpb_pkg::*;
#(
    parameter int NUM_ALT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ctl,
    input  logic               wr_io,
    input  logic [CTL_W-1:0]   wdata,
    input  logic               in_sync,
    input  logic [NUM_ALT-1:0] alt_out,
    input  logic [NUM_ALT-1:0] alt_oe,
    output ctl_t               ctl,
    output logic               out_bit,
    output logic               pad_out,
    output logic               pad_oe,
    output logic               pad_pu,
    output logic               pad_pd,
    output logic [DRV_W-1:0]   pad_drv
);
    pin_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctl) st_d.ctl = ctl_t'(wdata);
        if (wr_io)  st_d.out = wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ctl: CTL_RST, out: 1'b0};
        else        st_q <= st_d;
    end

    // pad source selection
    always_comb begin
        pad_out = 1'b0;
        pad_oe  = 1'b0;
        if (st_q.ctl.func == '0) begin
            pad_out = st_q.out;
            pad_oe  = st_q.ctl.oe;
        end else begin
            for (int k = 0; k < NUM_ALT; k++) begin
                if (st_q.ctl.func == FUNC_W'(k + 1)) begin
                    pad_out = alt_out[k];
                    pad_oe  = alt_oe[k];
                end
            end
        end
    end

    // pull resolution, keeper follows synchronised level
    always_comb begin
        pad_pu = 1'b0;
        pad_pd = 1'b0;
        case (st_q.ctl.pull)
            PULL_DOWN: pad_pd = 1'b1;
            PULL_UP:   pad_pu = 1'b1;
            PULL_KEEP: begin
                pad_pu = in_sync;
                pad_pd = ~in_sync;
            end
            default: ;
        endcase
    end

    assign ctl     = st_q.ctl;
    assign out_bit = st_q.out;
    assign pad_drv = st_q.ctl.drv;
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
    import gpb_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int NUM_ALT  = 7,
    parameter int ADDR_W   = 12,
    parameter int STRIDE   = 8,
    parameter int CTL_OFS  = 0,
    parameter int IO_OFS   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_we,
    input  logic                        bus_re,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic [NUM_PINS-1:0]         pad_in,
    input  logic [NUM_ALT*NUM_PINS-1:0] alt_out,
    input  logic [NUM_ALT*NUM_PINS-1:0] alt_oe,
    output logic [NUM_PINS-1:0]         pad_out,
    output logic [NUM_PINS-1:0]         pad_oe,
    output logic [NUM_PINS-1:0]         pad_pu,
    output logic [NUM_PINS-1:0]         pad_pd,
    output logic [DRV_W*NUM_PINS-1:0]   pad_drv,
    output logic [NUM_PINS-1:0]         gpio_in
);
    localparam int STRIDE_LG = $clog2(STRIDE);
    localparam int PIN_W     = ADDR_W - STRIDE_LG;

    typedef struct packed {
        logic [31:0] rdata;
    } bus_st_t;

    bus_st_t bus_d, bus_q;

    logic [PIN_W-1:0]     pin_sel;
    logic [STRIDE_LG-1:0] ofs;
    logic                 is_ctl, is_io;
    logic [NUM_PINS-1:0]  wr_ctl, wr_io;
    logic [NUM_PINS-1:0]  in_sync;
    logic [NUM_PINS-1:0]  out_bits;
    ctl_t                 ctl_arr [NUM_PINS];
    logic [NUM_ALT-1:0]   pin_alt_out [NUM_PINS];
    logic [NUM_ALT-1:0]   pin_alt_oe  [NUM_PINS];
    logic                 wdata_hi_unused;

    assign wdata_hi_unused = ^bus_wdata[31:CTL_W];

    assign pin_sel = bus_addr[ADDR_W-1:STRIDE_LG];
    assign ofs     = bus_addr[STRIDE_LG-1:0];
    assign is_ctl  = (ofs == STRIDE_LG'(CTL_OFS));
    assign is_io   = (ofs == STRIDE_LG'(IO_OFS));

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            wr_ctl[p] = bus_we && is_ctl && (pin_sel == PIN_W'(p));
            wr_io[p]  = bus_we && is_io  && (pin_sel == PIN_W'(p));
        end
    end

    // regroup function-major alternate vectors per pin
    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            for (int k = 0; k < NUM_ALT; k++) begin
                pin_alt_out[p][k] = alt_out[k*NUM_PINS + p];
                pin_alt_oe[p][k]  = alt_oe[k*NUM_PINS + p];
            end
        end
    end

    gpb_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (in_sync)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpb_pin #(.NUM_ALT(NUM_ALT)) u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctl  (wr_ctl[p]),
            .wr_io   (wr_io[p]),
            .wdata   (bus_wdata[CTL_W-1:0]),
            .in_sync (in_sync[p]),
            .alt_out (pin_alt_out[p]),
            .alt_oe  (pin_alt_oe[p]),
            .ctl     (ctl_arr[p]),
            .out_bit (out_bits[p]),
            .pad_out (pad_out[p]),
            .pad_oe  (pad_oe[p]),
            .pad_pu  (pad_pu[p]),
            .pad_pd  (pad_pd[p]),
            .pad_drv (pad_drv[DRV_W*p +: DRV_W])
        );
    end

    // read path: registered, old contents win over a same-cycle write
    always_comb begin
        bus_d = bus_q;
        if (bus_re) begin
            bus_d.rdata = '0;
            for (int p = 0; p < NUM_PINS; p++) begin
                if (pin_sel == PIN_W'(p)) begin
                    if (is_ctl) bus_d.rdata = 32'(ctl_arr[p]);
                    if (is_io)  bus_d.rdata = {30'd0, in_sync[p], out_bits[p]};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign bus_rdata = bus_q.rdata;
    assign gpio_in   = in_sync;
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker #(
    parameter int NUM_PINS = 8,
    parameter int NUM_ALT  = 7,
    parameter int ADDR_W   = 12,
    parameter int STRIDE   = 8,
    parameter int CTL_OFS  = 0,
    parameter int IO_OFS   = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_we,
    input logic                        bus_re,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [8:0]                  wdata_lo,
    input logic                        rdata_in_bit,
    input logic                        pad_in0,
    input logic [NUM_ALT*NUM_PINS-1:0] alt_out,
    input logic                        pad_out0,
    input logic                        pad_oe0,
    input logic [NUM_PINS-1:0]         pad_pu,
    input logic [NUM_PINS-1:0]         pad_pd,
    input logic [2:0]                  pad_drv0
);
    localparam logic [ADDR_W-1:0] CTL0 = ADDR_W'(CTL_OFS);
    localparam logic [ADDR_W-1:0] IO0  = ADDR_W'(IO_OFS);

    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        age <= '0;
        else if (age != 3) age <= age + 2'd1;
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_pd == '1 && pad_pu == '0 && !pad_oe0 && pad_drv0 == '0));

    assert_gpio_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == CTL0 && wdata_lo[2:0] == 3'd0)
        |=> (pad_oe0 == $past(wdata_lo[8])));

    assert_alt_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == CTL0 && wdata_lo[2:0] != 3'd0 && 32'(wdata_lo[2:0]) <= NUM_ALT)
        |=> (pad_out0 == alt_out[(32'($past(wdata_lo[2:0])) - 1) * NUM_PINS]));

    assert_pull_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);

    assert_drive_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == CTL0) |=> (pad_drv0 == $past(wdata_lo[7:5])));

    assert_sync_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(bus_re) && $past(bus_addr) == IO0)
        |-> (rdata_in_bit == $past(pad_in0, 3)));
endmodule

bind gpio_pad_bank gpb_checker #(
    .NUM_PINS (NUM_PINS),
    .NUM_ALT  (NUM_ALT),
    .ADDR_W   (ADDR_W),
    .STRIDE   (STRIDE),
    .CTL_OFS  (CTL_OFS),
    .IO_OFS   (IO_OFS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_re       (bus_re),
    .bus_addr     (bus_addr),
    .wdata_lo     (bus_wdata[8:0]),
    .rdata_in_bit (bus_rdata[1]),
    .pad_in0      (pad_in[0]),
    .alt_out      (alt_out),
    .pad_out0     (pad_out[0]),
    .pad_oe0      (pad_oe[0]),
    .pad_pu       (pad_pu),
    .pad_pd       (pad_pd),
    .pad_drv0     (pad_drv[2:0])
);

// File: tb/tb_gpio_pad_bank.sv
module tb_gpio_pad_bank;
    localparam int N  = 8;
    localparam int NA = 7;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0, bus_re = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [NA*N-1:0] alt_out = {8'h7E, 8'h81, 8'hF0, 8'h0F, 8'hCC, 8'h33, 8'hAA};
    logic [NA*N-1:0] alt_oe  = {8'h01, 8'hFE, 8'h55, 8'hAA, 8'h0F, 8'hF0, 8'h5A};
    logic [N-1:0]  pad_out, pad_oe, pad_pu, pad_pd, gpio_in;
    logic [3*N-1:0] pad_drv;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gpio_pad_bank #(.NUM_PINS(N), .NUM_ALT(NA), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .pad_drv(pad_drv), .gpio_in(gpio_in)
    );

    typedef struct packed {
        logic [2:0] pin;
        logic [8:0] ctl;
        logic       io_out;
        logic [3:0] exp;      // {out, oe, pu, pd}
        logic [2:0] exp_drv;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 9'h100, 1'b1, 4'b1100, 3'd0},
        '{3'd1, 9'h0F8, 1'b1, 4'b1010, 3'd7},
        '{3'd2, 9'h069, 1'b1, 4'b0001, 3'd3},
        '{3'd3, 9'h021, 1'b0, 4'b1100, 3'd1},
        '{3'd7, 9'h0B7, 1'b1, 4'b0001, 3'd5},
        '{3'd4, 9'h05B, 1'b0, 4'b0010, 3'd2},
        '{3'd5, 9'h0C2, 1'b0, 4'b1100, 3'd6},
        '{3'd6, 9'h08E, 1'b1, 4'b0101, 3'd4},
        '{3'd0, 9'h105, 1'b1, 4'b0100, 3'd0},
        '{3'd2, 9'h13C, 1'b0, 4'b1010, 3'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [AW-1:0] ctl_a(input int p);
        return AW'(p * 8);
    endfunction
    function automatic logic [AW-1:0] io_a(input int p);
        return AW'(p * 8 + 4);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", 32'(pad_oe), 32'h0);
        check("R1 pad_pd", 32'(pad_pd), 32'hFF);
        check("R1 pad_pu", 32'(pad_pu), 32'h0);
        check("R1 pad_drv", 32'(pad_drv), 32'h0);
        bus_read(ctl_a(3), rd);
        check("R1 ctl read", rd, 32'h008);
        bus_read(io_a(3), rd);
        check("R1 io read", rd, 32'h0);

        // table walk: R3 readback, R5/R6 source, R7/R8 pulls, R9 drive
        for (int v = 0; v < NV; v++) begin
            p = int'(VEC[v].pin);
            bus_write(ctl_a(p), 32'(VEC[v].ctl));
            bus_write(io_a(p), 32'(VEC[v].io_out));
            check(VEC[v].ctl[2:0] == 3'd0 ? "R5 out/oe" : "R6 out/oe",
                  {30'd0, pad_out[p], pad_oe[p]}, {30'd0, VEC[v].exp[3:2]});
            check(VEC[v].ctl[4:3] == 2'd2 ? "R8 keeper" : "R7 pulls",
                  {30'd0, pad_pu[p], pad_pd[p]}, {30'd0, VEC[v].exp[1:0]});
            check("R9 drive", 32'(pad_drv[3*p +: 3]), 32'(VEC[v].exp_drv));
            bus_read(ctl_a(p), rd);
            check("R3 ctl readback", rd, 32'(VEC[v].ctl));
        end

        // R10 synchroniser latency, change raced against a read strobe
        pad_in[1] = 1'b1;
        bus_read(io_a(1), rd);
        check("R10 read in change cycle", 32'(rd[1]), 32'h0);
        bus_read(io_a(1), rd);
        check("R10 read one cycle on", 32'(rd[1]), 32'h0);
        bus_read(io_a(1), rd);
        check("R10 read two cycles on", rd, 32'h3);

        // R8 keeper follows new level, R10 gpio_in
        pad_in[7] = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 keeper high", {30'd0, pad_pu[7], pad_pd[7]}, 32'h2);
        check("R10 gpio_in", 32'(gpio_in[7]), 32'h1);

        // R11 input visible on an alternate-function pin
        pad_in[2] = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(io_a(2), rd);
        check("R11 input on alt pin", 32'(rd[1]), 32'h1);

        // R4 input bit is read-only, upper bits zero
        pad_in[2] = 1'b0;
        repeat (3) @(negedge clk);
        bus_write(io_a(2), 32'hFFFF_FFFF);
        bus_read(io_a(2), rd);
        check("R4 io write mask", rd, 32'h1);

        // R3 upper control bits read zero
        bus_write(ctl_a(3), 32'hFFFF_FFFF);
        bus_read(ctl_a(3), rd);
        check("R3 ctl upper bits", rd, 32'h1FF);

        // R2 out-of-range and odd offsets
        bus_write(AW'(N * 8), 32'h0);
        bus_write(AW'(2), 32'hFF);
        bus_read(ctl_a(0), rd);
        check("R2 ignored writes", rd, 32'h105);
        check("R2 pin0 pads kept", {30'd0, pad_out[0], pad_oe[0]}, 32'h1);
        bus_read(AW'(N * 8), rd);
        check("R2 out-of-range read", rd, 32'h0);
        bus_read(AW'(2), rd);
        check("R2 odd offset read", rd, 32'h0);

        // R2 same-cycle read and write
        bus_we = 1'b1; bus_re = 1'b1; bus_addr = ctl_a(5); bus_wdata = 32'h0;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0;
        check("R2 same-cycle old data", bus_rdata, 32'h0C2);
        bus_read(ctl_a(5), rd);
        check("R2 new data after", rd, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule